// File: doc/BRIEF.md
# Debug TAP Chain Selector

This block is the target-side instruction and data-register routing logic of a processor debug port. A separate 16-state TAP controller drives it with one-hot state strobes. The block keeps a 5-bit instruction register and a stored scan-chain number. From these two it decides which data register sits between `tdi` and `tdo` during Shift-DR. The candidates are the chain-number register, an internal 32-bit debug status/control register, a set of external chains (instruction transfer, data transfer, debug register access), or a 1-bit bypass cell.

For every implemented external chain the block generates capture, shift and update strobes and a write qualifier. It also raises a one-cycle execution request when Run-Test/Idle is entered while an execution chain is stored and a test instruction is loaded. The debugger selects a chain by loading the chain-select instruction and scanning the chain number. It then reads the selected chain with the internal-test instruction or writes it with the external-test instruction. A shortcut instruction reaches the instruction-transfer chain without disturbing the stored chain number.

Top module: `dbgtap_chain_sel`

## Requirements
- R1: Asynchronous reset, and the Test-Logic-Reset strobe, set the instruction register to the bypass code 0x1F and the stored chain number to 0.
- R2: The instruction register captures 0b00001 and shifts LSB first from `tdi` to `tdo`. `ir_o` changes only on Update-IR.
- R3: Under instruction 0x02 the data register is a 5-bit chain-number field. It captures 0x10, which is shifted out LSB first, and the shifted value reaches `chain_o` only on Update-DR.
- R4: Instruction 0x1D routes the data path to chain 4 whatever chain is stored, and leaves `chain_o` unchanged.
- R5: With chain 1 stored, internal-test (0x0C) captures the 32-bit `dscr_rd` value and shifts it out LSB first. `dscr_we` is never raised.
- R6: With chain 1 stored, external-test (0x00) pulses `dscr_we` during Update-DR, and `dscr_wdata` then equals the 32 bits shifted in.
- R7: For external chains 4, 5 and 7 (bit c of the strobe vectors is chain c), the strobes follow the TAP state on the active chain only, and `tdo` follows `chain_tdo[c]`. Update and write strobes are raised only under 0x00 or 0x1D.
- R8: Any other instruction, or a test instruction with an unimplemented chain, selects a 1-bit bypass cell that captures 0.
- R9: `exec_go` pulses for one cycle on entry to Run-Test/Idle when the instruction is 0x00 or 0x0C and the stored chain is 4 or 5. Staying in Idle does not repeat it, and other instructions, including 0x1D, never raise it.
- R10: With chain 0 stored, `exec_go` stays low in Run-Test/Idle under every instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_reset | input | 1 | Test-Logic-Reset state strobe |
| tap_idle | input | 1 | Run-Test/Idle state strobe |
| tap_capture_dr | input | 1 | Capture-DR state strobe |
| tap_shift_dr | input | 1 | Shift-DR state strobe |
| tap_update_dr | input | 1 | Update-DR state strobe |
| tap_capture_ir | input | 1 | Capture-IR state strobe |
| tap_shift_ir | input | 1 | Shift-IR state strobe |
| tap_update_ir | input | 1 | Update-IR state strobe |
| tdi | input | 1 | Serial data in |
| dscr_rd | input | 32 | Status/control value captured on chain 1 |
| chain_tdo | input | 32 | Serial return of each external chain |
| tdo | output | 1 | Serial data out |
| ir_o | output | 5 | Current instruction |
| chain_o | output | 5 | Stored chain number |
| dscr_wdata | output | 32 | Value to write into the status/control register |
| dscr_we | output | 1 | Status/control write strobe |
| ch_capture | output | 32 | Per-chain capture strobe |
| ch_shift | output | 32 | Per-chain shift strobe |
| ch_update | output | 32 | Per-chain update strobe |
| ch_write | output | 32 | Per-chain write qualifier |
| exec_go | output | 1 | Idle-entry execution request |

## Verification
Two functions share one clock edge. The Update-DR edge that pulses the write strobe of chain 5 also arms the Idle-entry detector. The bench leaves Update-DR straight for Run-Test/Idle and stays there a second cycle. It expects the update strobe in the first state, one `exec_go` pulse in the following Idle, and none in the repeated Idle. The stored chain number is rewritten on the same kind of edge, so a later idle entry with chain 0 must produce no pulse.

// File: rtl/dbgsel_pkg.sv
package dbgsel_pkg;
   localparam int IR_W = 5;

   localparam logic [IR_W-1:0] IR_EXTEST    = 5'h00;
   localparam logic [IR_W-1:0] IR_CHAIN_SEL = 5'h02;
   localparam logic [IR_W-1:0] IR_INTEST    = 5'h0C;
   localparam logic [IR_W-1:0] IR_ITR_SHORT = 5'h1D;
   localparam logic [IR_W-1:0] IR_BYPASS    = 5'h1F;
   localparam logic [IR_W-1:0] IR_CAPTURE   = 5'h01;

   typedef enum logic [1:0] {
      DRK_BYPASS,
      DRK_CHSEL,
      DRK_DSCR,
      DRK_EXT
   } dr_kind_e;
endpackage

// File: rtl/dbgsel_ir.sv
module dbgsel_ir
   import dbgsel_pkg::*;
#(
   parameter logic [IR_W-1:0] RESET_CODE = IR_BYPASS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tap_reset,
   input  logic            cap,
   input  logic            shift,
   input  logic            upd,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic            sr_lsb
);
   logic [IR_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q <= RESET_CODE;
         sr   <= '0;
      end else begin
         if (tap_reset)  ir_q <= RESET_CODE;
         else if (upd)   ir_q <= sr;
         if (cap)        sr <= IR_CAPTURE;
         else if (shift) sr <= {tdi, sr[IR_W-1:1]};
      end
   end

   assign sr_lsb = sr[0];

   p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !tap_reset) |=> (ir_q == $past(ir_q)));
   p_ir_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tap_reset |=> (ir_q == RESET_CODE));
endmodule

// File: rtl/dbgsel_chsel.sv
module dbgsel_chsel #(
   parameter int              CH_W    = 5,
   parameter logic [CH_W-1:0] CAP_VAL = CH_W'(16)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tap_reset,
   input  logic            cap,
   input  logic            shift,
   input  logic            upd,
   input  logic            tdi,
   output logic [CH_W-1:0] chain_q,
   output logic            sr_lsb
);
   logic [CH_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         sr      <= '0;
      end else begin
         if (tap_reset)  chain_q <= '0;
         else if (upd)   chain_q <= sr;
         if (cap)        sr <= CAP_VAL;
         else if (shift) sr <= {tdi, sr[CH_W-1:1]};
      end
   end

   assign sr_lsb = sr[0];

   p_chain_only_on_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !tap_reset) |=> $stable(chain_q));
   p_chain_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (sr == CAP_VAL));
endmodule

// File: rtl/dbgsel_dscr.sv
module dbgsel_dscr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic         shift,
   input  logic         tdi,
   input  logic [W-1:0] rd_val,
   output logic [W-1:0] wdata,
   output logic         sr_lsb
);
   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (cap)   sr <= rd_val;
      else if (shift) sr <= {tdi, sr[W-1:1]};
   end

   assign wdata  = sr;
   assign sr_lsb = sr[0];

   p_dscr_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (sr == $past(rd_val)));
endmodule

// File: rtl/dbgtap_chain_sel.sv
module dbgtap_chain_sel
   import dbgsel_pkg::*;
#(
   parameter int                      CH_W        = 5,
   parameter int                      DSCR_W      = 32,
   parameter int                      DSCR_CHAIN  = 1,
   parameter int                      ITR_CHAIN   = 4,
   parameter int                      EXEC_A      = 4,
   parameter int                      EXEC_B      = 5,
   parameter logic [(1<<CH_W)-1:0]    EXT_MASK    = 'hB0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tap_reset,
   input  logic                       tap_idle,
   input  logic                       tap_capture_dr,
   input  logic                       tap_shift_dr,
   input  logic                       tap_update_dr,
   input  logic                       tap_capture_ir,
   input  logic                       tap_shift_ir,
   input  logic                       tap_update_ir,
   input  logic                       tdi,
   input  logic [DSCR_W-1:0]          dscr_rd,
   input  logic [(1<<CH_W)-1:0]       chain_tdo,
   output logic                       tdo,
   output logic [IR_W-1:0]            ir_o,
   output logic [CH_W-1:0]            chain_o,
   output logic [DSCR_W-1:0]          dscr_wdata,
   output logic                       dscr_we,
   output logic [(1<<CH_W)-1:0]       ch_capture,
   output logic [(1<<CH_W)-1:0]       ch_shift,
   output logic [(1<<CH_W)-1:0]       ch_update,
   output logic [(1<<CH_W)-1:0]       ch_write,
   output logic                       exec_go
);
   localparam int NCH = 1 << CH_W;
   localparam logic [CH_W-1:0] SEL_CAPTURE = CH_W'(16);

   if (CH_W < 5) begin : g_bad_chw
      $error("chain number must be at least 5 bits wide");
   end
   if (!EXT_MASK[ITR_CHAIN]) begin : g_bad_itr
      $error("instruction-transfer chain must be an external chain");
   end
   if (EXT_MASK[DSCR_CHAIN] || DSCR_CHAIN == ITR_CHAIN) begin : g_bad_dscr
      $error("status chain must be internal and distinct");
   end
   if (EXEC_A >= NCH || EXEC_B >= NCH) begin : g_bad_exec
      $error("execution chain out of range");
   end

   logic [IR_W-1:0] ir_q;
   logic            ir_lsb;
   logic [CH_W-1:0] chain_q;
   logic            sel_lsb;
   logic            dscr_lsb;
   logic            byp_q;
   logic            idle_q;
   logic            is_ext, is_int, is_itr, is_sel, test_ir, wr_ir, exec_chain;
   logic [CH_W-1:0] eff_chain;
   dr_kind_e        kind;

   dbgsel_ir #(.RESET_CODE(IR_BYPASS)) u_ir (
      .clk       (clk),
      .rst_n     (rst_n),
      .tap_reset (tap_reset),
      .cap       (tap_capture_ir),
      .shift     (tap_shift_ir),
      .upd       (tap_update_ir),
      .tdi       (tdi),
      .ir_q      (ir_q),
      .sr_lsb    (ir_lsb)
   );

   assign is_ext  = (ir_q == IR_EXTEST);
   assign is_int  = (ir_q == IR_INTEST);
   assign is_itr  = (ir_q == IR_ITR_SHORT);
   assign is_sel  = (ir_q == IR_CHAIN_SEL);
   assign test_ir = is_ext | is_int | is_itr;
   assign wr_ir   = is_ext | is_itr;

   dbgsel_chsel #(.CH_W(CH_W), .CAP_VAL(SEL_CAPTURE)) u_chsel (
      .clk       (clk),
      .rst_n     (rst_n),
      .tap_reset (tap_reset),
      .cap       (tap_capture_dr & is_sel),
      .shift     (tap_shift_dr & is_sel),
      .upd       (tap_update_dr & is_sel),
      .tdi       (tdi),
      .chain_q   (chain_q),
      .sr_lsb    (sel_lsb)
   );

   assign eff_chain = is_itr ? CH_W'(ITR_CHAIN) : chain_q;

   always_comb begin
      kind = DRK_BYPASS;
      if (is_sel)                                              kind = DRK_CHSEL;
      else if (test_ir && (eff_chain == CH_W'(DSCR_CHAIN)))    kind = DRK_DSCR;
      else if (test_ir && EXT_MASK[eff_chain])                 kind = DRK_EXT;
   end

   dbgsel_dscr #(.W(DSCR_W)) u_dscr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (tap_capture_dr && kind == DRK_DSCR),
      .shift  (tap_shift_dr && kind == DRK_DSCR),
      .tdi    (tdi),
      .rd_val (dscr_rd),
      .wdata  (dscr_wdata),
      .sr_lsb (dscr_lsb)
   );

   assign dscr_we = tap_update_dr && (kind == DRK_DSCR) && is_ext;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      if (EXT_MASK[c]) begin : g_ext
         logic hit;
         assign hit           = (kind == DRK_EXT) && (eff_chain == CH_W'(c));
         assign ch_capture[c] = tap_capture_dr & hit;
         assign ch_shift[c]   = tap_shift_dr & hit;
         assign ch_update[c]  = tap_update_dr & hit & wr_ir;
         assign ch_write[c]   = hit & wr_ir;
      end else begin : g_none
         assign ch_capture[c] = 1'b0;
         assign ch_shift[c]   = 1'b0;
         assign ch_update[c]  = 1'b0;
         assign ch_write[c]   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q  <= 1'b0;
         idle_q <= 1'b0;
      end else begin
         idle_q <= tap_idle;
         if (kind == DRK_BYPASS) begin
            if (tap_capture_dr)    byp_q <= 1'b0;
            else if (tap_shift_dr) byp_q <= tdi;
         end
      end
   end

   always_comb begin
      if (tap_shift_ir) tdo = ir_lsb;
      else begin
         unique case (kind)
            DRK_CHSEL: tdo = sel_lsb;
            DRK_DSCR:  tdo = dscr_lsb;
            DRK_EXT:   tdo = chain_tdo[eff_chain];
            default:   tdo = byp_q;
         endcase
      end
   end

   assign exec_chain = (chain_q == CH_W'(EXEC_A)) || (chain_q == CH_W'(EXEC_B));
   assign exec_go    = tap_idle & ~idle_q & (is_ext | is_int) & exec_chain;

   assign ir_o    = ir_q;
   assign chain_o = chain_q;

   p_one_chain_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_shift));
   p_update_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_update) |-> (ir_o == IR_EXTEST || ir_o == IR_ITR_SHORT));
   p_shortcut_keeps_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_itr && !tap_reset) |=> $stable(chain_o));
   p_dscr_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dscr_we |-> (ir_o == IR_EXTEST && chain_o == CH_W'(DSCR_CHAIN)));
   p_exec_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exec_go |=> !exec_go);
   p_exec_chain0_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_o == '0) |-> !exec_go);
endmodule

// File: tb/dbgtap_chain_sel_tb.sv
module dbgtap_chain_sel_tb;
   import dbgsel_pkg::*;

   localparam int S_RESET = 0, S_IDLE = 1, S_CDR = 2, S_SDR = 3, S_UDR = 4,
                  S_CIR = 5, S_SIR = 6, S_UIR = 7, S_NONE = 8;
   localparam int NV = 12;
   // entry = {instruction[11:7], stored chain[6:2], kind[1:0]}; kind 0 bypass, 1 select, 2 status, 3 external
   localparam logic [11:0] VEC [NV] = '{
      {5'h00, 5'd0, 2'd0}, {5'h0C, 5'd1, 2'd2}, {5'h00, 5'd1, 2'd2},
      {5'h0C, 5'd4, 2'd3}, {5'h00, 5'd5, 2'd3}, {5'h0C, 5'd7, 2'd3},
      {5'h00, 5'd3, 2'd0}, {5'h1D, 5'd0, 2'd3}, {5'h1D, 5'd5, 2'd3},
      {5'h02, 5'd7, 2'd1}, {5'h1F, 5'd1, 2'd0}, {5'h1E, 5'd4, 2'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [8:0] st = '0;
   logic tdi = 1'b0;
   logic [31:0] dscr_rd = '0;
   logic [31:0] chain_tdo = '0;
   logic tdo, dscr_we, exec_go;
   logic [4:0] ir_o, chain_o;
   logic [31:0] dscr_wdata, ch_capture, ch_shift, ch_update, ch_write;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic        s_tdo, s_we, s_exec;
   logic [31:0] s_wd, s_shift, s_upd;
   logic [31:0] r_dout, r_shift, r_upd, r_wd;
   logic        r_we;
   logic [4:0]  r_ircap;

   always #10 clk = ~clk;

   dbgtap_chain_sel u_dut (
      .clk(clk), .rst_n(rst_n),
      .tap_reset(st[S_RESET]), .tap_idle(st[S_IDLE]),
      .tap_capture_dr(st[S_CDR]), .tap_shift_dr(st[S_SDR]), .tap_update_dr(st[S_UDR]),
      .tap_capture_ir(st[S_CIR]), .tap_shift_ir(st[S_SIR]), .tap_update_ir(st[S_UIR]),
      .tdi(tdi), .dscr_rd(dscr_rd), .chain_tdo(chain_tdo),
      .tdo(tdo), .ir_o(ir_o), .chain_o(chain_o),
      .dscr_wdata(dscr_wdata), .dscr_we(dscr_we),
      .ch_capture(ch_capture), .ch_shift(ch_shift), .ch_update(ch_update),
      .ch_write(ch_write), .exec_go(exec_go)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int s, input logic b);
      @(negedge clk);
      st  = '0;
      if (s != S_NONE) st[s] = 1'b1;
      tdi = b;
      #2;
      s_tdo = tdo; s_we = dscr_we; s_wd = dscr_wdata; s_exec = exec_go;
      s_shift = ch_shift; s_upd = ch_update;
      @(posedge clk);
   endtask

   task automatic load_ir(input logic [4:0] code);
      step(S_CIR, 1'b0);
      for (int i = 0; i < 5; i++) begin
         step(S_SIR, code[i]);
         r_ircap[i] = s_tdo;
      end
      step(S_UIR, 1'b0);
      step(S_NONE, 1'b0);
   endtask

   task automatic scan_dr(input int n, input logic [31:0] din, input bit to_idle);
      r_dout = '0;
      step(S_CDR, 1'b0);
      for (int i = 0; i < n; i++) begin
         step(S_SDR, din[i]);
         r_dout[i] = s_tdo;
         if (i == 0) r_shift = s_shift;
      end
      step(S_UDR, 1'b0);
      r_upd = s_upd; r_we = s_we; r_wd = s_wd;
      if (!to_idle) step(S_NONE, 1'b0);
   endtask

   task automatic set_chain(input logic [4:0] c);
      load_ir(IR_CHAIN_SEL);
      scan_dr(5, {27'd0, c}, 1'b0);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      step(S_NONE, 1'b0);
      chk("R1 reset ir", 32'(ir_o), 32'h1F);
      chk("R1 reset chain", 32'(chain_o), 32'h0);

      // R2: capture pattern and update-only load
      load_ir(IR_INTEST);
      chk("R2 ir capture", 32'(r_ircap), 32'h01);
      chk("R2 ir loaded", 32'(ir_o), 32'(IR_INTEST));
      step(S_CIR, 1'b0);
      for (int i = 0; i < 5; i++) step(S_SIR, IR_EXTEST[i]);
      chk("R2 ir before update", 32'(ir_o), 32'(IR_INTEST));
      step(S_UIR, 1'b0);
      step(S_NONE, 1'b0);
      chk("R2 ir after update", 32'(ir_o), 32'(IR_EXTEST));

      // R3: chain number deferred to update
      load_ir(IR_CHAIN_SEL);
      step(S_CDR, 1'b0);
      for (int i = 0; i < 5; i++) step(S_SDR, (i == 0 || i == 2));
      chk("R3 chain before update", 32'(chain_o), 32'h0);
      step(S_UDR, 1'b0);
      step(S_NONE, 1'b0);
      chk("R3 chain after update", 32'(chain_o), 32'h5);

      // R1: TAP reset strobe
      step(S_RESET, 1'b0);
      step(S_NONE, 1'b0);
      chk("R1 tap reset ir", 32'(ir_o), 32'h1F);
      chk("R1 tap reset chain", 32'(chain_o), 32'h0);

      // table of instruction / chain combinations
      for (int v = 0; v < NV; v++) begin
         logic [4:0] ir_c, ch_c;
         logic [1:0] kd;
         int idx;
         ir_c = VEC[v][11:7]; ch_c = VEC[v][6:2]; kd = VEC[v][1:0];
         set_chain(ch_c);
         load_ir(ir_c);
         case (kd)
            2'd0: begin
               scan_dr(2, 32'h3, 1'b0);
               chk("R8 bypass path", 32'(r_dout[1:0]), 32'h2);
            end
            2'd1: begin
               scan_dr(5, {27'd0, ch_c}, 1'b0);
               chk("R3 select capture", 32'(r_dout[4:0]), 32'h10);
               chk("R3 chain kept", 32'(chain_o), 32'(ch_c));
            end
            2'd2: begin
               dscr_rd = 32'hC0DE_0000 | 32'(v);
               scan_dr(32, 32'h5A5A_0000 | 32'(v), 1'b0);
               chk("R5 status read", r_dout, dscr_rd);
               if (ir_c == IR_EXTEST) begin
                  chk("R6 status write strobe", 32'(r_we), 32'h1);
                  chk("R6 status write data", r_wd, 32'h5A5A_0000 | 32'(v));
               end else begin
                  chk("R5 no write under internal test", 32'(r_we), 32'h0);
               end
            end
            default: begin
               idx = (ir_c == IR_ITR_SHORT) ? 4 : int'(ch_c);
               chain_tdo = 32'h1 << idx;
               scan_dr(3, 32'h0, 1'b0);
               chk("R7 external tdo route", 32'(r_dout[2:0]), 32'h7);
               chk("R7 shift strobe", r_shift, 32'h1 << idx);
               chk("R7 update strobe", r_upd,
                   (ir_c == IR_INTEST) ? 32'h0 : (32'h1 << idx));
               if (ir_c == IR_ITR_SHORT)
                  chk("R4 shortcut keeps chain", 32'(chain_o), 32'(ch_c));
               chain_tdo = '0;
            end
         endcase
      end

      // R9: idle-entry execution request
      set_chain(5'd4);
      load_ir(IR_INTEST);
      step(S_IDLE, 1'b0);
      chk("R9 exec on idle entry", 32'(s_exec), 32'h1);
      step(S_IDLE, 1'b0);
      chk("R9 no repeat in idle", 32'(s_exec), 32'h0);
      step(S_NONE, 1'b0);
      step(S_IDLE, 1'b0);
      chk("R9 exec on re-entry", 32'(s_exec), 32'h1);
      step(S_NONE, 1'b0);
      load_ir(IR_ITR_SHORT);
      step(S_IDLE, 1'b0);
      chk("R9 shortcut does not execute", 32'(s_exec), 32'h0);
      step(S_NONE, 1'b0);
      load_ir(IR_BYPASS);
      step(S_IDLE, 1'b0);
      chk("R9 bypass does not execute", 32'(s_exec), 32'h0);
      step(S_NONE, 1'b0);

      // same edge: chain 5 update strobe then idle entry
      set_chain(5'd5);
      load_ir(IR_EXTEST);
      chain_tdo = 32'h20;
      scan_dr(2, 32'h0, 1'b1);
      chk("R7 update before idle", r_upd, 32'h20);
      step(S_IDLE, 1'b0);
      chk("R9 exec after update", 32'(s_exec), 32'h1);
      step(S_IDLE, 1'b0);
      chk("R9 single pulse", 32'(s_exec), 32'h0);
      step(S_NONE, 1'b0);
      chain_tdo = '0;

      // R10: chain 0 blocks execution
      set_chain(5'd0);
      load_ir(IR_EXTEST);
      step(S_IDLE, 1'b0);
      chk("R10 chain0 external test", 32'(s_exec), 32'h0);
      step(S_NONE, 1'b0);
      load_ir(IR_INTEST);
      step(S_IDLE, 1'b0);
      chk("R10 chain0 internal test", 32'(s_exec), 32'h0);
      step(S_NONE, 1'b0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule